// File: doc/BRIEF.md
# Synchronizable PWM Gate Sequencer

This block is the digital timing core of a synchronous buck power stage. A phase counter running on the system clock defines the switching period. While no sync pulses arrive, the period is a fixed number of clocks. Each falling edge seen on the sync input cuts the current period short and starts a fresh one at once. A one-clock strobe marks every period boundary, so that downstream fault-counting and undervoltage logic can count cycles.

Within each period a small state machine drives the gate enables in a fixed order. It holds both gates off for a dead interval, then turns the high-side enable on. It turns the high side off when the on-time reaches the latched duty value, the maximum on-time, or a qualified overcurrent event, whichever comes first. A second dead interval follows, and then the low-side enable conducts until the next period begins. The overcurrent flag is masked for a blanking window at the start of every high-side pulse. Once it has cut a pulse, the high side stays off for the rest of the period. Deasserting the enable forces both gates off. Switching resumes at the first period boundary after the enable returns.

The sync input is treated as synchronous to the system clock. The reset input is asynchronous, and its release is synchronised inside the block. The duty value is a count of system clocks.

Top module: `pwm_gate_seq`

## Requirements
- R1: With the sync input held low or idle, `cyc_o` pulses for exactly one clock every PERIOD clocks (default 40).
- R2: A falling edge on `sync_i`, meaning high at one clock edge and low at the next, starts a new period at that edge. `cyc_o` is high in the following clock, and later periods are counted from that edge.
- R3: `hs_o` and `ls_o` are never high in the same clock. Every change from one enable to the other passes through at least DEAD clocks (default 2) with both low.
- R4: When `oc_i` is high at a clock edge while `hs_o` is high and the blanking window has elapsed, `hs_o` is low from the next clock. It stays low until the next period starts.
- R5: `duty_i` is latched at each period start. `hs_o` rises DEAD clocks after the `cyc_o` clock and stays high for min(duty, MAXON) clocks (default MAXON 34, 85% of the period). The second dead interval then follows, and after it `ls_o` stays high until the period ends.
- R6: `oc_i` has no effect during the first BLANK clocks (default 3) of each high-side pulse.
- R7: When `en_i` is low at a clock edge, both enables are low from the next clock. After `en_i` returns high, both stay low until the next period start, and normal sequencing resumes from there.
- R8: A period start that arrives while `hs_o` is high turns `hs_o` off at that edge. Both enables then stay low for DEAD clocks before the new high-side pulse.
- R9: A latched duty of zero produces no high-side pulse. `ls_o` rises 2*DEAD clocks after the period start and stays on to the end of the period.
- R10: While reset is held, `hs_o`, `ls_o` and `cyc_o` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sync_i | input | 1 | External sync; each falling edge starts a period |
| duty_i | input | CNT_W | High-side on-time in clocks, latched at period start |
| oc_i | input | 1 | Overcurrent flag from the high-side sense comparator |
| en_i | input | 1 | Switching enable |
| hs_o | output | 1 | High-side gate enable |
| ls_o | output | 1 | Low-side gate enable |
| cyc_o | output | 1 | One-clock period start strobe |

## Verification
Duty values of 0, 1, a mid value, exactly MAXON, and above MAXON are each run over a full period. Across these runs the rising and falling positions and the pulse widths separate the dead-time offset, the on-time cap and the zero-duty path. Overcurrent is applied once inside the blanking window and once after it within the same pulse: an unmasked flag early would cut the pulse at the wrong place, and a pulse that resumes after a cut would show up in the high-side count. Sync pulses spaced closer than the free-running period, a sync edge in the middle of a high-side pulse, and sync then held low together show whether the external edge really replaces the internal period, how a cut pulse is sequenced, and that free-running resumes. A mid-period duty change and an enable drop during a pulse expose any missing latch on the duty value and any stale state at re-enable.

// File: rtl/pwm_seq_pkg.sv
package pwm_seq_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  // Gate sequencing states; LEAD precedes the high side, TRAIL follows it.
  typedef enum logic [2:0] {
    GS_OFF   = 3'd0,
    GS_LEAD  = 3'd1,
    GS_HIGH  = 3'd2,
    GS_TRAIL = 3'd3,
    GS_LOW   = 3'd4
  } gate_st_t;
endpackage

// File: rtl/pwm_rst_sync.sv
module pwm_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [1:0] stage_q;

  // Assert asynchronously, release after two clock edges.
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_o = stage_q[1];
endmodule

// File: rtl/pwm_period_gen.sv
module pwm_period_gen #(
  parameter int CNT_W  = 8,
  parameter int PERIOD = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_i,
  output logic start_o,
  output logic cyc_o
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic             sync_q;
  logic [CNT_W-1:0] ph_q, ph_d;
  logic             sync_fall;

  assign sync_fall = sync_q & ~sync_i;
  assign start_o   = sync_fall | (ph_q == LAST);

  always_comb begin
    ph_d = ph_q + ONE;
    if (start_o) ph_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b0;
      ph_q   <= '0;
      cyc_o  <= 1'b0;
    end else begin
      sync_q <= sync_i;
      ph_q   <= ph_d;
      cyc_o  <= start_o;
    end
  end

  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q <= LAST); // R1
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_o |=> !cyc_o); // R1
  AST_SYNC_TAKEOVER: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_q && !sync_i) |=> (cyc_o && ph_q == '0)); // R2
endmodule

// File: rtl/pwm_gate_fsm.sv
module pwm_gate_fsm
  import pwm_seq_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int DEAD  = 2,
  parameter int BLANK = 3,
  parameter int MAXON = 34
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             en_i,
  input  logic             oc_i,
  input  logic [CNT_W-1:0] duty_i,
  output logic             hs_o,
  output logic             ls_o
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
  localparam logic [CNT_W-1:0] DEAD_M1 = CNT_W'(DEAD - 1);
  localparam logic [CNT_W-1:0] BLANK_C = CNT_W'(BLANK);
  localparam logic [CNT_W-1:0] MAXON_C = CNT_W'(MAXON);

  gate_st_t         st_q, st_d;
  logic [CNT_W-1:0] tcnt_q, tcnt_d;
  logic [CNT_W-1:0] lim_q, lim_d;
  logic             oc_hit, on_done;

  assign oc_hit  = oc_i && (tcnt_q >= BLANK_C);
  assign on_done = (tcnt_q + ONE) >= lim_q;

  always_comb begin
    st_d   = st_q;
    tcnt_d = tcnt_q + ONE;
    lim_d  = lim_q;
    if (!en_i) begin
      st_d   = GS_OFF;
      tcnt_d = '0;
    end else if (start_i) begin
      st_d   = GS_LEAD;
      tcnt_d = '0;
      lim_d  = (duty_i > MAXON_C) ? MAXON_C : duty_i;
    end else begin
      unique case (st_q)
        GS_LEAD: if (tcnt_q == DEAD_M1) begin
          st_d   = (lim_q == '0) ? GS_TRAIL : GS_HIGH;
          tcnt_d = '0;
        end
        GS_HIGH: if (on_done || oc_hit) begin
          st_d   = GS_TRAIL;
          tcnt_d = '0;
        end
        GS_TRAIL: if (tcnt_q == DEAD_M1) begin
          st_d   = GS_LOW;
          tcnt_d = '0;
        end
        default: tcnt_d = '0;  // OFF and LOW need no count
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= GS_OFF;
      tcnt_q <= '0;
      lim_q  <= '0;
    end else begin
      st_q   <= st_d;
      tcnt_q <= tcnt_d;
      lim_q  <= lim_d;
    end
  end

  assign hs_o = (st_q == GS_HIGH);
  assign ls_o = (st_q == GS_LOW);

  AST_HS_THEN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    hs_o |=> !ls_o); // R3
  AST_LS_THEN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ls_o |=> !hs_o); // R3
  AST_MAX_ON: assert property (@(posedge clk) disable iff (!rst_n)
    hs_o |-> (tcnt_q < MAXON_C)); // R5
  AST_BLANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_o && en_i && !start_i && tcnt_q < BLANK_C && (tcnt_q + ONE) < lim_q) |=> hs_o); // R6
  AST_OC_CUT: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_o && oc_i && tcnt_q >= BLANK_C) |=> !hs_o); // R4
  AST_OC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == GS_TRAIL || st_q == GS_LOW) && !start_i) |=> !hs_o); // R4
  AST_DISABLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (!hs_o && !ls_o)); // R7
  AST_START_CUT: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (!hs_o && !ls_o)); // R8
endmodule

// File: rtl/pwm_gate_seq.sv
module pwm_gate_seq #(
  parameter int CNT_W  = 8,
  parameter int PERIOD = 40,
  parameter int DEAD   = 2,
  parameter int BLANK  = 3,
  parameter int MAXON  = 34
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic             oc_i,
  input  logic             en_i,
  output logic             hs_o,
  output logic             ls_o,
  output logic             cyc_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic srst_n;
  logic start;

  pwm_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (srst_n)
  );

  pwm_period_gen #(.CNT_W(CNT_W), .PERIOD(PERIOD)) u_period (
    .clk     (clk),
    .rst_n   (srst_n),
    .sync_i  (sync_i),
    .start_o (start),
    .cyc_o   (cyc_o)
  );

  pwm_gate_fsm #(.CNT_W(CNT_W), .DEAD(DEAD), .BLANK(BLANK), .MAXON(MAXON)) u_fsm (
    .clk     (clk),
    .rst_n   (srst_n),
    .start_i (start),
    .en_i    (en_i),
    .oc_i    (oc_i),
    .duty_i  (duty_i),
    .hs_o    (hs_o),
    .ls_o    (ls_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !srst_n |-> (!hs_o && !ls_o && !cyc_o)); // R10
endmodule

// File: tb/sim_pwm_gate_seq.sv
module sim_pwm_gate_seq;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int CNT_W  = 8;
  localparam int PERIOD = 40;
  localparam int DEAD   = 2;
  localparam int BLANK  = 3;
  localparam int MAXON  = 34;

  logic clk = 1'b0;
  logic rst_n, sync_i, oc_i, en_i;
  logic [CNT_W-1:0] duty_i;
  logic hs_o, ls_o, cyc_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int ovl_err = 0, gap_err = 0, off_run = 0, last_src = 0;

  always #5 clk = ~clk;

  pwm_gate_seq #(.CNT_W(CNT_W), .PERIOD(PERIOD), .DEAD(DEAD), .BLANK(BLANK), .MAXON(MAXON)) u0 (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .duty_i(duty_i), .oc_i(oc_i),
    .en_i(en_i), .hs_o(hs_o), .ls_o(ls_o), .cyc_o(cyc_o)
  );

  // Continuous overlap and dead-gap monitor for R3
  always @(negedge clk) begin
    if (rst_n) begin
      if (hs_o && ls_o) ovl_err++;
      if (hs_o || ls_o) begin
        if (last_src != 0 && last_src != (hs_o ? 1 : 2) && off_run < DEAD) gap_err++;
        last_src = hs_o ? 1 : 2;
        off_run  = 0;
      end else off_run++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_cyc();
    @(negedge clk);
    while (!cyc_o) @(negedge clk);
  endtask

  // Runs one full period with duty d, returns counts and first positions.
  task automatic measure(input int d, output int nhs, output int nls, output int fhs, output int fls);
    duty_i = CNT_W'(d);
    wait_cyc();
    nhs = 0; nls = 0; fhs = -1; fls = -1;
    for (int i = 0; i < PERIOD; i++) begin
      if (hs_o) begin nhs++; if (fhs < 0) fhs = i; end
      if (ls_o) begin nls++; if (fls < 0) fls = i; end
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; sync_i = 1'b0; oc_i = 1'b0; en_i = 1'b1; duty_i = 8'd10;
    repeat (5) @(negedge clk);
    chk(!hs_o && !ls_o && !cyc_o, "R10 outputs quiet in reset", {hs_o, ls_o, cyc_o}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_duty(input int d);
    int nhs, nls, fhs, fls, lim;
    lim = (d > MAXON) ? MAXON : d;
    measure(d, nhs, nls, fhs, fls);
    if (lim == 0) begin
      chk(nhs == 0, "R9 no high pulse", nhs, 0);
      chk(fls == 2*DEAD, "R9 low start", fls, 2*DEAD);
      chk(nls == PERIOD - 2*DEAD, "R9 low width", nls, PERIOD - 2*DEAD);
    end else begin
      chk(fhs == DEAD, "R5 high start", fhs, DEAD);
      chk(nhs == lim, "R5 high width", nhs, lim);
      chk(fls == 2*DEAD + lim, "R5 low start", fls, 2*DEAD + lim);
      chk(nls == PERIOD - 2*DEAD - lim, "R5 low width", nls, PERIOD - 2*DEAD - lim);
    end
  endtask

  task automatic t_free_period();
    int n;
    wait_cyc();
    n = 0;
    do begin @(negedge clk); n++; end while (!cyc_o);
    chk(n == PERIOD, "R1 free-run period", n, PERIOD);
  endtask

  task automatic t_duty_latch();
    int nhs;
    duty_i = 8'd10;
    wait_cyc();
    duty_i = 8'd20;
    nhs = 0;
    for (int i = 0; i < PERIOD; i++) begin
      if (hs_o) nhs++;
      @(negedge clk);
    end
    chk(nhs == 10, "R5 duty latched at start", nhs, 10);
  endtask

  task automatic t_oc();
    int nhs;
    bit blank_ok;
    duty_i = 8'd30;
    wait_cyc();
    nhs = 0; blank_ok = 1'b0;
    for (int i = 0; i < PERIOD; i++) begin
      int k;
      k = i - DEAD;
      if (hs_o) nhs++;
      if (k == BLANK) blank_ok = hs_o;
      oc_i = (k >= 0 && k < BLANK) || (k >= 5 && k < 10);
      @(negedge clk);
    end
    oc_i = 1'b0;
    chk(blank_ok, "R6 oc masked in blanking", blank_ok, 1);
    chk(nhs == 6, "R4 high cut and held off", nhs, 6);
  endtask

  task automatic sync_pulse();
    @(negedge clk); sync_i = 1'b1;
    @(negedge clk); sync_i = 1'b0;
    @(negedge clk);
    chk(cyc_o, "R2 strobe after sync fall", cyc_o, 1);
  endtask

  task automatic t_sync();
    int extra, n;
    duty_i = 8'd10;
    extra = 0;
    for (int r = 0; r < 3; r++) begin
      sync_pulse();
      for (int i = 0; i < 25; i++) begin
        @(negedge clk);
        if (cyc_o) extra++;
      end
    end
    chk(extra == 0, "R2 sync replaces internal period", extra, 0);
    sync_pulse();
    n = 0;
    do begin @(negedge clk); n++; end while (!cyc_o);
    chk(n == PERIOD, "R1 free-run resumes after sync", n, PERIOD);
  endtask

  task automatic t_sync_mid_pulse();
    int seen;
    duty_i = 8'd30;
    wait_cyc();
    repeat (DEAD + 10) @(negedge clk);
    chk(hs_o, "R8 high before sync", hs_o, 1);
    sync_i = 1'b1;
    @(negedge clk); sync_i = 1'b0;
    @(negedge clk);
    seen = {hs_o, ls_o, cyc_o};
    chk(cyc_o && !hs_o && !ls_o, "R8 cut at sync start", seen, 1);
    for (int i = 1; i < DEAD; i++) begin
      @(negedge clk);
      chk(!hs_o && !ls_o, "R8 dead gap after cut", {hs_o, ls_o}, 0);
    end
    @(negedge clk);
    chk(hs_o, "R8 new pulse after gap", hs_o, 1);
  endtask

  task automatic t_enable();
    int bad, nhs, nls, fhs, fls;
    duty_i = 8'd10;
    wait_cyc();
    repeat (DEAD + 2) @(negedge clk);
    en_i = 1'b0;
    @(negedge clk);
    chk(!hs_o && !ls_o, "R7 off one clock after disable", {hs_o, ls_o}, 0);
    bad = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (hs_o || ls_o) bad++;
    end
    chk(bad == 0, "R7 stays off while disabled", bad, 0);
    en_i = 1'b1;
    bad = 0;
    @(negedge clk);
    while (!cyc_o) begin
      if (hs_o || ls_o) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R7 idle until period start", bad, 0);
    measure(10, nhs, nls, fhs, fls);
    chk(nhs == 10 && fhs == DEAD, "R7 normal after re-enable", nhs, 10);
  endtask

  initial begin
    t_reset();
    t_free_period();
    t_duty(10);
    t_duty(1);
    t_duty(MAXON);
    t_duty(50);
    t_duty(0);
    t_duty_latch();
    t_oc();
    t_sync();
    t_sync_mid_pulse();
    t_enable();
    chk(ovl_err == 0, "R3 no overlap", ovl_err, 0);
    chk(gap_err == 0, "R3 dead gap on every handover", gap_err, 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule